// File: doc/BRIEF.md
# Global Shutter Exposure Sequencer

This block drives the two active-low exposure strobes of a freeze-frame image sensor. A low pulse on `pg_n_o` empties every photosite and starts a new integration. A low pulse on `tx_n_o` moves the collected charge into each pixel's analog store. The exposure time is the gap between the two pulses. Neither pulse alone empties the analog store. When both are driven low together, the photosites and the store are cleared in one operation, and the block offers this as a separate clear request while idle.

The external readout logic supplies the current readout row index and a strobe at each row boundary. Exposure is then counted in whole row periods. The block has three modes, selected by `mode_i`:

- Overlapped mode (`2'b00`): exposure runs while the previous frame is still being read out. The transfer pulse is placed on the last row of the window. The clear pulse is placed the requested number of rows earlier, so both pulses are interleaved with readout.
- Back-to-back mode (`2'b01`): the exposure completes first. Then a one-cycle `readout_go_o` strobe lets digitization start. The next exposure begins once readout reaches the window's last row.
- Single-shot mode (`2'b10`, with `2'b11` behaving the same): one frame is captured and the block returns to idle.

Top module: `gs_expo_seq`

## Requirements
- R1: While reset is asserted, `pg_n_o` and `tx_n_o` are high, and `frame_rdy_o`, `readout_go_o` and `clamp_err_o` are low.
- R2: Every low pulse on `pg_n_o` or `tx_n_o` lasts exactly PULSE_CYC consecutive clock cycles (default 4).
- R3: A one-cycle `clear_i` while idle drives `pg_n_o` and `tx_n_o` low in the same PULSE_CYC cycles. While a capture is running, `clear_i` has no effect on either strobe.
- R4: In overlapped mode (`mode_i`=00), `pg_n_o` falls in the cycle after the `row_tick_i` whose `row_idx_i` equals `win_last_i` minus the integration rows.
- R5: In overlapped mode, `tx_n_o` falls in the cycle after the `row_tick_i` whose `row_idx_i` equals `win_last_i`.
- R6: In overlapped mode, an integration request larger than `win_last_i` is clamped to `win_last_i`, so the clear pulse lands on row 0. It also sets `clamp_err_o`, which stays high until reset.
- R7: In back-to-back mode (`mode_i`=01), `pg_n_o` falls in the cycle after `start_i` is sampled. `tx_n_o` falls in the cycle after the N-th `row_tick_i` seen after `pg_n_o` returns high, where N is the integration rows.
- R8: In back-to-back and single-shot modes, `readout_go_o` is high for one cycle, together with `frame_rdy_o`. It never rises in overlapped mode.
- R9: `frame_rdy_o` is high for exactly the first cycle in which `tx_n_o` is back high after a capture pulse.
- R10: In single-shot mode (`mode_i`=10 or 11), one start produces exactly one `pg_n_o` pulse, one `tx_n_o` pulse and one `readout_go_o`, then nothing further.
- R11: Back-to-back and overlapped captures repeat until `stop_i`. In back-to-back mode, the next `pg_n_o` falls in the cycle after the `row_tick_i` at row `win_last_i`. After `stop_i`, the frame in progress completes and no further pulse follows.
- R12: An integration request of zero rows is treated as one row.
- R13: `pg_n_o` and `tx_n_o` are never low at the same time, except during the combined clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_n_i | input | 1 | Asynchronous active-low reset |
| mode_i | input | 2 | 00 overlapped, 01 back-to-back, 10/11 single shot; sampled at start |
| start_i | input | 1 | One-cycle start request, taken while idle |
| stop_i | input | 1 | One-cycle request to stop after the current frame |
| clear_i | input | 1 | One-cycle combined clear request, taken while idle |
| int_rows_i | input | ROW_W | Integration time in row periods, sampled at each frame start |
| win_last_i | input | ROW_W | Last row of the frame or window, sampled at each frame start |
| row_idx_i | input | ROW_W | Current readout row index |
| row_tick_i | input | 1 | One-cycle strobe marking a row boundary for `row_idx_i` |
| pg_n_o | output | 1 | Active-low photosite clear / integration start |
| tx_n_o | output | 1 | Active-low charge transfer into pixel memory |
| frame_rdy_o | output | 1 | One-cycle flag: a frame has been captured into pixel memory |
| readout_go_o | output | 1 | One-cycle permission to start digitization (non-overlapped modes) |
| clamp_err_o | output | 1 | Sticky flag: an overlapped-mode request was clamped |

## Verification
The embedded properties rely on a few conditions on the inputs:

- Row strobes are spaced by more than PULSE_CYC plus two cycles, so a strobe never lands while a pulse on the same strobe line is still active.
- `win_last_i` is at least 1, so a clamped request still leaves one row between the two pulses.
- The stimulus generates row strobes every 16 cycles against a window whose last row is 11.
- Configuration inputs change only while the block is idle.
- `start_i`, `stop_i` and `clear_i` are single-cycle pulses, issued at points where their effect is fully defined.

// File: rtl/gs_expo_pkg.sv
package gs_expo_pkg;

  typedef enum logic [1:0] {
    MODE_OVLP  = 2'b00,
    MODE_B2B   = 2'b01,
    MODE_SHOT  = 2'b10,
    MODE_SHOT2 = 2'b11
  } mode_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CLR,
    ST_WAIT_PG,
    ST_PG,
    ST_INTEG,
    ST_WAIT_TX,
    ST_TX,
    ST_DRAIN
  } st_e;

endpackage

// File: rtl/gs_pulse_gen.sv
module gs_pulse_gen #(
  parameter int PULSE_CYC = 4,
  localparam int CW = $clog2(PULSE_CYC + 1)
) (
  input  logic clk_i,
  input  logic rst_n_i,
  input  logic fire_i,
  output logic out_n_o,
  output logic last_o
);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (fire_i) begin
      cnt_d = CW'(PULSE_CYC);
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - CW'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign out_n_o = (cnt_q == '0);
  assign last_o  = (cnt_q == CW'(1));

  // R2
  fire_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    fire_i |-> (cnt_q == '0));

  // R2
  count_step_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    ((cnt_q != '0) && !fire_i) |=> (cnt_q == $past(cnt_q) - CW'(1)));

endmodule

// File: rtl/gs_row_calc.sv
module gs_row_calc #(
  parameter int ROW_W = 10
) (
  input  logic             ovlp_i,
  input  logic [ROW_W-1:0] int_rows_i,
  input  logic [ROW_W-1:0] win_last_i,
  output logic [ROW_W-1:0] eff_rows_o,
  output logic [ROW_W-1:0] start_row_o,
  output logic             clamp_o
);

  logic over;

  always_comb begin
    over    = (int_rows_i > win_last_i);
    clamp_o = ovlp_i && over;
    if (int_rows_i == '0) begin
      eff_rows_o = ROW_W'(1);
    end else if (clamp_o) begin
      eff_rows_o = win_last_i;
    end else begin
      eff_rows_o = int_rows_i;
    end
    start_row_o = win_last_i - eff_rows_o;
  end

endmodule

// File: rtl/gs_expo_ctrl.sv
module gs_expo_ctrl
  import gs_expo_pkg::*;
#(
  parameter int ROW_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_n_i,
  input  logic [1:0]       mode_i,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic             clear_i,
  input  logic             row_tick_i,
  input  logic [ROW_W-1:0] row_idx_i,
  input  logic [ROW_W-1:0] win_last_i,
  input  logic [ROW_W-1:0] eff_rows_i,
  input  logic [ROW_W-1:0] start_row_i,
  input  logic             clamp_i,
  input  logic             pg_last_i,
  input  logic             tx_last_i,
  output logic             calc_ovlp_o,
  output logic             fire_pg_o,
  output logic             fire_tx_o,
  output logic             clr_act_o,
  output logic             frame_rdy_o,
  output logic             readout_go_o,
  output logic             clamp_err_o
);

  st_e              st_q, st_d;
  mode_e            mode_q, mode_d;
  logic [ROW_W-1:0] end_q, end_d;
  logic [ROW_W-1:0] eff_q, eff_d;
  logic [ROW_W-1:0] srow_q, srow_d;
  logic [ROW_W-1:0] icnt_q, icnt_d;
  logic [ROW_W-1:0] icnt_inc;
  logic             stop_q, stop_d;
  logic             rdy_q, rdy_d;
  logic             go_q, go_d;
  logic             err_q, err_d;
  logic             latch;
  logic             is_ovlp, is_shot, stop_now;

  assign is_ovlp     = (mode_q == MODE_OVLP);
  assign is_shot     = mode_q[1];
  assign stop_now    = stop_q | stop_i;
  assign icnt_inc    = icnt_q + 1'b1;
  assign calc_ovlp_o = (st_q == ST_IDLE) ? (mode_i == 2'b00) : is_ovlp;

  always_comb begin
    st_d      = st_q;
    mode_d    = mode_q;
    icnt_d    = icnt_q;
    rdy_d     = 1'b0;
    go_d      = 1'b0;
    fire_pg_o = 1'b0;
    fire_tx_o = 1'b0;
    latch     = 1'b0;
    stop_d    = (st_q == ST_IDLE) ? 1'b0 : stop_now;
    unique case (st_q)
      ST_IDLE: begin
        if (start_i) begin
          mode_d = mode_e'(mode_i);
          latch  = 1'b1;
          if (mode_i == 2'b00) begin
            st_d = ST_WAIT_PG;
          end else begin
            fire_pg_o = 1'b1;
            st_d      = ST_PG;
          end
        end else if (clear_i) begin
          fire_pg_o = 1'b1;
          fire_tx_o = 1'b1;
          st_d      = ST_CLR;
        end
      end
      ST_CLR: begin
        if (pg_last_i) st_d = ST_IDLE;
      end
      ST_WAIT_PG: begin
        if (row_tick_i && (row_idx_i == srow_q)) begin
          fire_pg_o = 1'b1;
          st_d      = ST_PG;
        end
      end
      ST_PG: begin
        if (pg_last_i) begin
          icnt_d = '0;
          st_d   = is_ovlp ? ST_WAIT_TX : ST_INTEG;
        end
      end
      ST_INTEG: begin
        if (row_tick_i) begin
          if (icnt_inc == eff_q) begin
            fire_tx_o = 1'b1;
            st_d      = ST_TX;
          end else begin
            icnt_d = icnt_inc;
          end
        end
      end
      ST_WAIT_TX: begin
        if (row_tick_i && (row_idx_i == end_q)) begin
          fire_tx_o = 1'b1;
          st_d      = ST_TX;
        end
      end
      ST_TX: begin
        if (tx_last_i) begin
          rdy_d = 1'b1;
          go_d  = !is_ovlp;
          if (is_shot || stop_now) begin
            st_d = ST_IDLE;
          end else if (is_ovlp) begin
            latch = 1'b1;
            st_d  = ST_WAIT_PG;
          end else begin
            st_d = ST_DRAIN;
          end
        end
      end
      ST_DRAIN: begin
        if (row_tick_i && (row_idx_i == end_q)) begin
          if (stop_now) begin
            st_d = ST_IDLE;
          end else begin
            latch     = 1'b1;
            fire_pg_o = 1'b1;
            st_d      = ST_PG;
          end
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_comb begin
    end_d  = end_q;
    eff_d  = eff_q;
    srow_d = srow_q;
    err_d  = err_q;
    if (latch) begin
      end_d  = win_last_i;
      eff_d  = eff_rows_i;
      srow_d = start_row_i;
      err_d  = err_q | clamp_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      st_q   <= ST_IDLE;
      mode_q <= MODE_OVLP;
      end_q  <= '0;
      eff_q  <= '0;
      srow_q <= '0;
      icnt_q <= '0;
      stop_q <= 1'b0;
      rdy_q  <= 1'b0;
      go_q   <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      mode_q <= mode_d;
      end_q  <= end_d;
      eff_q  <= eff_d;
      srow_q <= srow_d;
      icnt_q <= icnt_d;
      stop_q <= stop_d;
      rdy_q  <= rdy_d;
      go_q   <= go_d;
      err_q  <= err_d;
    end
  end

  assign clr_act_o    = (st_q == ST_CLR);
  assign frame_rdy_o  = rdy_q;
  assign readout_go_o = go_q;
  assign clamp_err_o  = err_q;

  // R8
  go_mode_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    go_q |-> (mode_q != MODE_OVLP));

  // R9
  rdy_after_tx_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    $rose(rdy_q) |-> $past(tx_last_i));

  // R6
  err_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    err_q |=> err_q);

  // R10
  shot_end_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (rdy_q && is_shot) |-> (st_q == ST_IDLE));

endmodule

// File: rtl/gs_expo_seq.sv
module gs_expo_seq #(
  parameter int ROW_W     = 10,
  parameter int PULSE_CYC = 4
) (
  input  logic             clk_i,
  input  logic             rst_n_i,
  input  logic [1:0]       mode_i,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic             clear_i,
  input  logic [ROW_W-1:0] int_rows_i,
  input  logic [ROW_W-1:0] win_last_i,
  input  logic [ROW_W-1:0] row_idx_i,
  input  logic             row_tick_i,
  output logic             pg_n_o,
  output logic             tx_n_o,
  output logic             frame_rdy_o,
  output logic             readout_go_o,
  output logic             clamp_err_o
);

  localparam int NCH = 2;

  logic             rst_s0, rst_sn;
  logic [ROW_W-1:0] eff_rows, start_row;
  logic             clamp, calc_ovlp, clr_act;
  logic [NCH-1:0]   fire_v, out_n_v, last_v;

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      rst_s0 <= 1'b0;
      rst_sn <= 1'b0;
    end else begin
      rst_s0 <= 1'b1;
      rst_sn <= rst_s0;
    end
  end

  gs_row_calc #(.ROW_W(ROW_W)) u_calc (
    .ovlp_i      (calc_ovlp),
    .int_rows_i  (int_rows_i),
    .win_last_i  (win_last_i),
    .eff_rows_o  (eff_rows),
    .start_row_o (start_row),
    .clamp_o     (clamp)
  );

  gs_expo_ctrl #(.ROW_W(ROW_W)) u_ctrl (
    .clk_i        (clk_i),
    .rst_n_i      (rst_sn),
    .mode_i       (mode_i),
    .start_i      (start_i),
    .stop_i       (stop_i),
    .clear_i      (clear_i),
    .row_tick_i   (row_tick_i),
    .row_idx_i    (row_idx_i),
    .win_last_i   (win_last_i),
    .eff_rows_i   (eff_rows),
    .start_row_i  (start_row),
    .clamp_i      (clamp),
    .pg_last_i    (last_v[0]),
    .tx_last_i    (last_v[1]),
    .calc_ovlp_o  (calc_ovlp),
    .fire_pg_o    (fire_v[0]),
    .fire_tx_o    (fire_v[1]),
    .clr_act_o    (clr_act),
    .frame_rdy_o  (frame_rdy_o),
    .readout_go_o (readout_go_o),
    .clamp_err_o  (clamp_err_o)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_chan
    gs_pulse_gen #(.PULSE_CYC(PULSE_CYC)) u_pulse (
      .clk_i   (clk_i),
      .rst_n_i (rst_sn),
      .fire_i  (fire_v[g]),
      .out_n_o (out_n_v[g]),
      .last_o  (last_v[g])
    );
  end

  assign pg_n_o = out_n_v[0];
  assign tx_n_o = out_n_v[1];

  // R13
  both_low_chk: assert property (@(posedge clk_i) disable iff (!rst_sn)
    (!pg_n_o && !tx_n_o) |-> clr_act);

  // R8
  go_with_rdy_chk: assert property (@(posedge clk_i) disable iff (!rst_sn)
    readout_go_o |-> frame_rdy_o);

endmodule

// File: tb/gs_expo_seq_tb_top.sv
module gs_expo_seq_tb_top;
  localparam int RW = 10;
  localparam int PC = 4;
  localparam int ROW_CYC = 16;
  localparam int WIN = 11;

  logic clk = 1'b0;
  logic rst_n;
  logic [1:0] mode;
  logic start, stop, clear, row_tick;
  logic [RW-1:0] int_rows, win_last, row_idx;
  logic pg_n, tx_n, rdy, go, err;

  always #2.5 clk = ~clk;

  gs_expo_seq #(.ROW_W(RW), .PULSE_CYC(PC)) dut_i (
    .clk_i(clk), .rst_n_i(rst_n), .mode_i(mode), .start_i(start),
    .stop_i(stop), .clear_i(clear), .int_rows_i(int_rows),
    .win_last_i(win_last), .row_idx_i(row_idx), .row_tick_i(row_tick),
    .pg_n_o(pg_n), .tx_n_o(tx_n), .frame_rdy_o(rdy),
    .readout_go_o(go), .clamp_err_o(err)
  );

  int nchk = 0, nerr = 0;
  int cyc = 0;
  int pg_falls = 0, tx_falls = 0, both_low = 0, rdy_cnt = 0, go_cnt = 0;
  int rdy_terr = 0, go_err = 0, len_err = 0;
  int pg_len = 0, tx_len = 0, pg_last_len = 0, tx_last_len = 0;
  int pg_fall_cyc = 0, pg_fall_row = -1, tx_fall_row = -1;
  int pg_fall_tick = 0, tx_fall_tick = 0;
  int ticks_since_pg = 0, tx_ticks = 0, start_cyc = 0;
  logic pg_prev = 1'b1, tx_prev = 1'b1, prev_tick = 1'b0;
  int prev_row = 0;

  always @(negedge clk) begin
    cyc++;
    if (start) start_cyc = cyc;
    if (!pg_n && pg_prev) begin
      pg_falls++; pg_fall_cyc = cyc; pg_fall_tick = prev_tick;
      pg_fall_row = prev_row; ticks_since_pg = 0;
    end
    if (!tx_n && tx_prev) begin
      tx_falls++; tx_fall_tick = prev_tick; tx_fall_row = prev_row;
      tx_ticks = ticks_since_pg;
    end
    if (!pg_n) pg_len++;
    if (pg_n && !pg_prev) begin
      pg_last_len = pg_len; if (pg_len != PC) len_err++; pg_len = 0;
    end
    if (!tx_n) tx_len++;
    if (tx_n && !tx_prev) begin
      tx_last_len = tx_len; if (tx_len != PC) len_err++; tx_len = 0;
    end
    if (row_tick && pg_n) ticks_since_pg++;
    if (!pg_n && !tx_n) both_low++;
    if (rdy) begin
      rdy_cnt++;
      if (!(tx_n && !tx_prev)) rdy_terr++;
    end
    if (go) begin
      go_cnt++;
      if (!rdy) go_err++;
    end
    prev_tick = row_tick; prev_row = int'(row_idx);
    pg_prev = pg_n; tx_prev = tx_n;
  end

  // row readout emulation: strobe every ROW_CYC cycles, rows 0..WIN
  initial begin
    row_tick = 1'b0; row_idx = '0;
    forever begin
      repeat (ROW_CYC - 1) @(posedge clk);
      #1;
      row_idx = (row_idx == RW'(WIN)) ? '0 : row_idx + 1'b1;
      row_tick = 1'b1;
      @(posedge clk); #1;
      row_tick = 1'b0;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic pulse_in(input int which);
    @(posedge clk); #1;
    case (which)
      0: start = 1'b1;
      1: stop = 1'b1;
      default: clear = 1'b1;
    endcase
    @(posedge clk); #1;
    start = 1'b0; stop = 1'b0; clear = 1'b0;
  endtask

  task automatic wait_rdy(input int target);
    for (int i = 0; i < 3000; i++) begin
      if (rdy_cnt >= target) break;
      @(posedge clk); #1;
    end
  endtask

  task automatic t_reset;
    rst_n = 1'b0; mode = 2'b00; start = 0; stop = 0; clear = 0;
    int_rows = '0; win_last = RW'(WIN);
    cycles(3);
    @(negedge clk);
    chk(pg_n && tx_n, "R1 strobes high in reset", {pg_n, tx_n}, 3);
    chk(!rdy && !go && !err, "R1 flags low in reset", {rdy, go, err}, 0);
    @(posedge clk); #1 rst_n = 1'b1;
    cycles(4);
  endtask

  task automatic t_clear;
    int b_both = both_low, b_rdy = rdy_cnt, b_pg = pg_falls;
    pulse_in(2);
    cycles(10);
    chk(both_low - b_both == PC, "R3 combined clear overlap", both_low - b_both, PC);
    chk(pg_last_len == PC && tx_last_len == PC, "R2 clear pulse width", pg_last_len, PC);
    chk(pg_falls - b_pg == 1 && rdy_cnt == b_rdy, "R3 clear is one pulse, no frame", pg_falls - b_pg, 1);
  endtask

  task automatic t_ovlp(input int intr, input int exp_start, input bit exp_err);
    int b_rdy = rdy_cnt, b_go = go_cnt, b_pg = pg_falls, b_tx = tx_falls;
    int b_len = len_err, b_terr = rdy_terr, b_both;
    mode = 2'b00; int_rows = RW'(intr);
    pulse_in(0);
    wait_rdy(b_rdy + 1);
    chk(pg_fall_tick == 1 && pg_fall_row == exp_start, "R4 overlapped clear row", pg_fall_row, exp_start);
    chk(tx_fall_tick == 1 && tx_fall_row == WIN, "R5 overlapped transfer row", tx_fall_row, WIN);
    chk(err == exp_err, "R6 clamp flag", err, exp_err);
    b_both = both_low;
    cycles(2);
    pulse_in(2);
    cycles(3);
    chk(both_low == b_both && pg_n && tx_n, "R3 clear ignored while running", both_low - b_both, 0);
    pulse_in(1);
    wait_rdy(b_rdy + 2);
    chk(pg_fall_row == exp_start, "R4 second frame clear row", pg_fall_row, exp_start);
    cycles(ROW_CYC * (WIN + 1) * 2);
    chk(pg_falls - b_pg == 2 && tx_falls - b_tx == 2, "R11 overlapped stops after frame", pg_falls - b_pg, 2);
    chk(go_cnt == b_go, "R8 no readout_go in overlapped", go_cnt - b_go, 0);
    chk(len_err == b_len, "R2 pulse widths", len_err - b_len, 0);
    chk(rdy_terr == b_terr && rdy_cnt - b_rdy == 2, "R9 frame_rdy timing", rdy_cnt - b_rdy, 2);
  endtask

  task automatic t_b2b(input int intr, input int exp_ticks);
    int b_rdy = rdy_cnt, b_go = go_cnt, b_pg = pg_falls, b_goerr = go_err, b_terr = rdy_terr;
    mode = 2'b01; int_rows = RW'(intr);
    pulse_in(0);
    cycles(1);
    chk(pg_fall_cyc == start_cyc + 1, "R7 clear follows start", pg_fall_cyc, start_cyc + 1);
    wait_rdy(b_rdy + 1);
    chk(tx_ticks == exp_ticks, "R7 R12 transfer after row count", tx_ticks, exp_ticks);
    chk(go_cnt - b_go == 1 && go_err == b_goerr, "R8 readout_go with frame_rdy", go_cnt - b_go, 1);
    wait_rdy(b_rdy + 2);
    chk(pg_fall_tick == 1 && pg_fall_row == WIN, "R11 next exposure after last row", pg_fall_row, WIN);
    pulse_in(1);
    cycles(ROW_CYC * (WIN + 1) * 2);
    chk(pg_falls - b_pg == 2, "R11 back-to-back stop", pg_falls - b_pg, 2);
    chk(rdy_terr == b_terr, "R9 frame_rdy timing", rdy_terr - b_terr, 0);
  endtask

  task automatic t_shot;
    int b_pg = pg_falls, b_tx = tx_falls, b_go = go_cnt, b_rdy = rdy_cnt;
    mode = 2'b10; int_rows = RW'(2);
    pulse_in(0);
    cycles(ROW_CYC * (WIN + 1) * 3);
    chk(pg_falls - b_pg == 1 && tx_falls - b_tx == 1, "R10 single shot pulses", pg_falls - b_pg, 1);
    chk(go_cnt - b_go == 1 && rdy_cnt - b_rdy == 1, "R10 single shot readout_go", go_cnt - b_go, 1);
  endtask

  initial begin
    rst_n = 1'b0;
    t_reset();
    t_clear();
    t_ovlp(4, WIN - 4, 1'b0);
    t_b2b(3, 3);
    t_b2b(0, 1);
    t_shot();
    t_ovlp(20, 0, 1'b1);
    t_b2b(2, 2);
    chk(err == 1'b1, "R6 clamp flag sticky", err, 1);
    chk(both_low == PC, "R13 strobes low together only in clear", both_low, PC);
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

endmodule